// File: doc/BRIEF.md
# Content-Addressable Memory with Consuming Search

This block is a small associative store driven through one operation port. On every clock edge it accepts one operation: idle, store, search-and-keep (peek) or search-and-delete (take). A store places a data word at an explicit entry address. A search compares a key against every live entry at once. It returns the lowest entry index that holds that key, together with a found flag.

The take operation reports the matching index and retires that entry in the same edge. A later search for the same key therefore finds the next live copy, or nothing. Each entry carries a live bit. Reset fills every entry with zero and marks it live. A retired entry never matches again until a store revives it.

Results are registered. A done pulse marks the cycle after each accepted non-idle operation, and the result outputs hold steady until the next such operation. Control is a two-state machine. `ST_WAIT` means no result is fresh. `ST_REPORT` means the previous edge executed an operation. The transitions are:
- `GO_REPORT`: any non-idle opcode, taken from either state.
- `GO_WAIT`: an idle opcode.
- `RESET`: forces `ST_WAIT`.

Top module: `assoc_cam`

## Requirements
- R1: The 2-bit opcode on `op_i` is encoded as 2'b00 idle, 2'b01 store, 2'b10 peek (search and keep), 2'b11 take (search and delete). Exactly one operation is accepted per clock edge.
- R2: After reset every entry holds zero and is live. `done_o`, `found_o` and `res_addr_o` read 0, and a search for key zero returns index 0.
- R3: A search reports `found_o`=1 and the lowest index whose live entry equals the key.
- R4: A peek leaves contents and live bits unchanged, so repeating it gives the same result.
- R5: A take that hits clears the live bit of the reported entry in the same edge. A following search for that key returns the next higher live match, if any.
- R6: A search with no live match gives `found_o`=0 and `res_addr_o`=0.
- R7: A store writes `data_i` at `addr_i`, marks that entry live, and overwrites any earlier content there. Its result is `found_o`=0 with `res_addr_o` equal to the stored address.
- R8: `done_o` is high in exactly the cycle after a non-idle operation is accepted. The results of that operation appear in the same cycle (one-cycle latency), including on back-to-back operations.
- R9: An idle opcode produces no done pulse and leaves `found_o` and `res_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation code (R1) |
| addr_i | input | $clog2(N) | Entry address for a store |
| data_i | input | W | Store data, or search key |
| res_addr_o | output | $clog2(N) | Result entry index |
| found_o | output | 1 | A live match was found |
| done_o | output | 1 | One-cycle pulse after an operation |

## Verification
The bench builds the block with its defaults: N=8 entries of W=8 bits. At that size it can address both end entries, 0 and 7, directly. It can also place duplicate keys at a low and a high index to observe priority, and let a take uncover the higher copy. Because reset leaves zero in every entry, key zero matches across the whole array. Retiring entries one by one therefore walks the priority encoder upward through real indices.

// File: rtl/assoc_cam_pkg.sv
`timescale 1ns/1ps
package assoc_cam_pkg;
    typedef enum logic [1:0] {
        CMOP_IDLE  = 2'b00,
        CMOP_STORE = 2'b01,
        CMOP_PEEK  = 2'b10,
        CMOP_TAKE  = 2'b11
    } cam_op_e;

    typedef enum logic {
        ST_WAIT   = 1'b0,
        ST_REPORT = 1'b1
    } cam_state_e;
endpackage

// File: rtl/cam_store.sv
`timescale 1ns/1ps
module cam_store #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          kill_en,
    input  logic [AW-1:0] kill_idx,
    output logic [W-1:0]  ent_data [N],
    output logic [N-1:0]  ent_vld
);
    // One register slice per entry; reset leaves zero content, live.
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic sel_wr;
        logic sel_kill;
        assign sel_wr   = wr_en   && (wr_addr  == AW'(g));
        assign sel_kill = kill_en && (kill_idx == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_data[g] <= '0;
                ent_vld[g]  <= 1'b1;
            end else if (sel_wr) begin
                ent_data[g] <= wr_data;
                ent_vld[g]  <= 1'b1;
            end else if (sel_kill) begin
                ent_vld[g]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cam_match.sv
`timescale 1ns/1ps
module cam_match #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic [W-1:0]  ent_data [N],
    input  logic [N-1:0]  ent_vld,
    input  logic [W-1:0]  key,
    output logic          hit,
    output logic [AW-1:0] hit_idx
);
    logic [N-1:0] eq_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq_vec[g] = ent_vld[g] && (ent_data[g] == key);
    end

    // Scan from the top so that the lowest matching index is written last.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq_vec[i]) begin
                hit     = 1'b1;
                hit_idx = AW'(i);
            end
        end
    end
endmodule

// File: rtl/cam_ctrl.sv
`timescale 1ns/1ps
module cam_ctrl
    import assoc_cam_pkg::*;
#(
    parameter int N  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op,
    input  logic [AW-1:0] addr,
    input  logic          hit,
    input  logic [AW-1:0] hit_idx,
    output logic          wr_en,
    output logic          kill_en,
    output logic [AW-1:0] res_addr,
    output logic          found,
    output logic          done
);
    cam_state_e state_q, state_d;
    cam_op_e    op_e;

    assign op_e = cam_op_e'(op);

    always_comb begin
        wr_en   = 1'b0;
        kill_en = 1'b0;
        state_d = ST_WAIT;
        unique case (op_e)
            CMOP_IDLE:  state_d = ST_WAIT;
            CMOP_STORE: begin
                wr_en   = 1'b1;
                state_d = ST_REPORT;
            end
            CMOP_PEEK:  state_d = ST_REPORT;
            CMOP_TAKE: begin
                kill_en = hit;
                state_d = ST_REPORT;
            end
            default:    state_d = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    assign done = (state_q == ST_REPORT);

    // Result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_addr <= '0;
            found    <= 1'b0;
        end else begin
            unique case (op_e)
                CMOP_IDLE: begin
                    res_addr <= res_addr;
                    found    <= found;
                end
                CMOP_STORE: begin
                    res_addr <= addr;
                    found    <= 1'b0;
                end
                CMOP_PEEK, CMOP_TAKE: begin
                    res_addr <= hit ? hit_idx : '0;
                    found    <= hit;
                end
                default: begin
                    res_addr <= res_addr;
                    found    <= found;
                end
            endcase
        end
    end
endmodule

// File: rtl/assoc_cam.sv
`timescale 1ns/1ps
module assoc_cam #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  data_i,
    output logic [AW-1:0] res_addr_o,
    output logic          found_o,
    output logic          done_o
);
    logic [W-1:0]  ent_data [N];
    logic [N-1:0]  ent_vld;
    logic          hit;
    logic [AW-1:0] hit_idx;
    logic          wr_en;
    logic          kill_en;

    cam_store #(.N(N), .W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (addr_i),
        .wr_data  (data_i),
        .kill_en  (kill_en),
        .kill_idx (hit_idx),
        .ent_data (ent_data),
        .ent_vld  (ent_vld)
    );

    cam_match #(.N(N), .W(W)) u_match (
        .ent_data (ent_data),
        .ent_vld  (ent_vld),
        .key      (data_i),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    cam_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_i),
        .addr     (addr_i),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .wr_en    (wr_en),
        .kill_en  (kill_en),
        .res_addr (res_addr_o),
        .found    (found_o),
        .done     (done_o)
    );
endmodule

// File: rtl/assoc_cam_chk.sv
`timescale 1ns/1ps
module assoc_cam_chk #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    op_i,
    input logic [AW-1:0] addr_i,
    input logic [AW-1:0] res_addr_o,
    input logic          found_o,
    input logic          done_o,
    input logic [N-1:0]  ent_vld
);
    AST_DONE_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b00) |=> done_o); // R8

    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00) |=> !done_o); // R9

    AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00) |=> ($stable(found_o) && $stable(res_addr_o))); // R9

    AST_STORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01) |=> (!found_o && res_addr_o == $past(addr_i))); // R7

    AST_STORE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01) |=> ent_vld[$past(addr_i)]); // R7

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[1] == 1'b1) |=> (found_o || res_addr_o == '0)); // R6

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b10) |=> $stable(ent_vld)); // R4

    AST_PEEK_HIT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b10) |=> (!found_o || ent_vld[res_addr_o])); // R3

    AST_TAKE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b11) |=> (!found_o || !ent_vld[res_addr_o])); // R5
endmodule

bind assoc_cam assoc_cam_chk #(.N(N), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .res_addr_o (res_addr_o),
    .found_o    (found_o),
    .done_o     (done_o),
    .ent_vld    (ent_vld)
);

// File: tb/tb_assoc_cam.sv
`timescale 1ns/1ps
module tb_assoc_cam;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int AW = $clog2(N);
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic [AW-1:0] addr_i = '0;
    logic [W-1:0]  data_i = '0;
    logic [AW-1:0] res_addr_o;
    logic          found_o;
    logic          done_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    assoc_cam #(.N(N), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i),
        .data_i(data_i), .res_addr_o(res_addr_o), .found_o(found_o),
        .done_o(done_o)
    );

    // Opcodes per R1: 00 idle, 01 store, 10 peek, 11 take
    localparam logic [1:0] V_OP [NV] = '{
        2'b10, 2'b01, 2'b01, 2'b10, 2'b11, 2'b11, 2'b11, 2'b10, 2'b01,
        2'b01, 2'b10, 2'b11, 2'b10, 2'b01, 2'b10, 2'b10, 2'b01, 2'b10};
    localparam logic [2:0] V_AD [NV] = '{
        3'd0, 3'd0, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd3,
        3'd5, 3'd0, 3'd0, 3'd0, 3'd5, 3'd0, 3'd0, 3'd0, 3'd0};
    localparam logic [7:0] V_DT [NV] = '{
        8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h5A,
        8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'hC3, 8'h5A, 8'hC3, 8'h11, 8'h11};
    localparam logic       V_FD [NV] = '{
        1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
        1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [2:0] V_RA [NV] = '{
        3'd0, 3'd0, 3'd7, 3'd0, 3'd7, 3'd0, 3'd0, 3'd1, 3'd3,
        3'd5, 3'd3, 3'd3, 3'd5, 3'd5, 3'd0, 3'd5, 3'd0, 3'd0};
    // Requirement tag per vector
    localparam string V_RQ [NV] = '{
        "R2", "R7", "R7", "R3", "R5", "R6", "R5", "R5", "R7",
        "R7", "R3", "R5", "R5", "R7", "R6", "R4", "R7", "R3"};

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [2:0] a,
                         input logic [7:0] d);
        op_i   = op;
        addr_i = a;
        data_i = d;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "done after reset", done_o, 0);
        chk("R2", "found after reset", found_o, 0);
        chk("R2", "addr after reset", res_addr_o, 0);

        // Table walk: one operation per cycle, back to back (R8)
        for (int i = 0; i < NV; i++) begin
            drive(V_OP[i], V_AD[i], V_DT[i]);
            chk("R8", $sformatf("done vec %0d", i), done_o, 1);
            chk(V_RQ[i], $sformatf("found vec %0d", i), found_o, V_FD[i]);
            chk(V_RQ[i], $sformatf("addr vec %0d", i), res_addr_o, V_RA[i]);
        end

        // Idle holds the result and gives no done (R9)
        drive(2'b10, 3'd0, 8'hC3);
        chk("R4", "peek C3 again addr", res_addr_o, 5);
        drive(2'b00, 3'd2, 8'h00);
        chk("R9", "no done on idle", done_o, 0);
        chk("R9", "found held", found_o, 1);
        chk("R9", "addr held", res_addr_o, 5);
        drive(2'b00, 3'd6, 8'h11);
        chk("R8", "done stays low", done_o, 0);
        chk("R9", "addr still held", res_addr_o, 5);

        // Reset mid-run restores zero content, all live (R2)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "addr cleared", res_addr_o, 0);
        drive(2'b10, 3'd0, 8'hC3);
        chk("R6", "old key gone after reset", found_o, 0);
        drive(2'b11, 3'd0, 8'h00);
        chk("R2", "zero found after reset", found_o, 1);
        chk("R5", "take zero addr", res_addr_o, 0);
        drive(2'b11, 3'd0, 8'h00);
        chk("R5", "next zero copy", res_addr_o, 1);
        drive(2'b10, 3'd0, 8'h00);
        chk("R5", "peek after two takes", res_addr_o, 2);
        drive(2'b00, 3'd0, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule